// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one multi-register memory transfer command into a stream of single-word memory beats. A command carries a base address, a 16-bit register selection mask, a direction bit (up or down), a timing bit (offset applied before or after each access), a write-back request bit and a load/store bit. The block counts the selected registers, works out the first address from the mode and emits one beat per selected register. Each beat carries a word-aligned address and the index of the register that belongs at that address.

Registers are always visited from the lowest index to the highest, and addresses always rise by one word per beat, in every mode. The direction bit only moves the window of addresses below or above the base. When the last beat is accepted, the block presents the updated base value for one cycle, together with the write-back request, so the register file can commit it. A command whose mask is empty is refused with a one-cycle error pulse and produces no beats.

Both stream edges use valid/ready. A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no sequence is running, so a new command waits until the current one ends. A beat is consumed when `beat_valid` and `beat_ready` are both high. While `beat_valid` is high and `beat_ready` is low, every beat field holds its value. `beat_ready` may change in any cycle.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset `beat_valid`, `seq_done` and `list_err` are low and `cmd_ready` is high.
- R2: An accepted command with N set mask bits yields exactly N beats. Mask bit i selects register index i, and `beat_reg` takes the selected indices in strictly ascending order.
- R3: The first beat address depends on the mode, written as {up,pre}. For 2'b10 it is base. For 2'b11 it is base+4. For 2'b00 it is base-4N+4. For 2'b01 it is base-4N. All arithmetic is modulo 2^32.
- R4: Each following beat address is the previous one plus 4. Every beat address has bits [1:0] equal to zero.
- R5: While `beat_valid` is high and `beat_ready` is low, `beat_addr`, `beat_reg`, `beat_last` and `beat_load` keep their values into the next cycle.
- R6: `beat_last` is high on the final beat of a command and low on every other beat. `beat_load` equals the command's load bit on every beat.
- R7: `seq_done` pulses high for exactly one cycle, in the cycle after the final beat is accepted. In that cycle `done_base` is base+4N when up=1 and base-4N when up=0, and `done_wb` equals the command's write-back bit.
- R8: A command with an all-zero mask raises `list_err` for one cycle, in the cycle after it is accepted. It produces no beat and no `seq_done`.
- R9: `cmd_ready` is low while beats are pending. `cmd_valid` and the command fields have no effect on the running sequence's beats or its `done_base`.
- R10: A 16-register transfer whose address window crosses 0 wraps modulo 2^32 and still follows R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_base | input | 32 | Base address |
| cmd_list | input | 16 | Register selection mask, bit i = register i |
| cmd_up | input | 1 | 1 = window above base, 0 = below |
| cmd_pre | input | 1 | 1 = offset before each access, 0 = after |
| cmd_wb | input | 1 | Request base write-back |
| cmd_load | input | 1 | 1 = load, 0 = store |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Memory side accepts the beat |
| beat_addr | output | 32 | Word-aligned access address |
| beat_reg | output | 4 | Register index for this beat |
| beat_last | output | 1 | Final beat of the command |
| beat_load | output | 1 | Direction of this beat |
| seq_done | output | 1 | One-cycle pulse after the final beat |
| done_wb | output | 1 | Write-back requested, valid with seq_done |
| done_base | output | 32 | Updated base value, valid with seq_done |
| list_err | output | 1 | One-cycle pulse for an empty mask |

## Verification
The assertions take two things for granted. Reset is held for at least one clock, and `beat_ready` is the only input that shapes a running sequence. The command inputs are sampled only in the cycle a command is accepted. The stimulus keeps to this but tests its edges. It toggles `beat_ready` at random with several duty levels, and it offers junk commands on `cmd_valid` while a sequence runs. It drops `cmd_valid` in the same cycle it accepts the final beat, so the junk never lands in the idle cycle that follows. Directed cases cover the descending push example, single-bit masks at both ends, a full mask wrapping through address zero, an unaligned base and an empty mask.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  // {up, pre} encoding of the four addressing modes
  typedef enum logic [1:0] {
    MODE_DN_POST = 2'b00,
    MODE_DN_PRE  = 2'b01,
    MODE_UP_POST = 2'b10,
    MODE_UP_PRE  = 2'b11
  } xfer_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/blkxfer_count.sv
module blkxfer_count #(
  parameter int NREG  = 16,
  parameter int CNT_W = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]  mask,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) begin
      count = count + CNT_W'(mask[i]);
    end
  end
endmodule

// File: rtl/blkxfer_span.sv
module blkxfer_span
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  xfer_mode_e        mode,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] final_base
);
  localparam int SHIFT = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(WORD_BYTES) - ADDR_W'(1));

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] raw_first;

  assign span = ADDR_W'(count) << SHIFT;

  always_comb begin
    unique case (mode)
      MODE_UP_POST: raw_first = base;
      MODE_UP_PRE:  raw_first = base + STEP;
      MODE_DN_POST: raw_first = base - span + STEP;
      default:      raw_first = base - span;
    endcase
  end

  assign first_addr = raw_first & ALIGN_MASK;
  assign final_base = mode[1] ? (base + span) : (base - span);
endmodule

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   mask,
  output logic [IDX_W-1:0]  idx,
  output logic              single,
  output logic [NREG-1:0]   mask_rest
);
  logic [NREG-1:0] lowest;

  assign lowest    = mask & (~mask + NREG'(1));
  assign mask_rest = mask & ~lowest;
  assign single    = (mask != '0) && (mask_rest == '0);

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
  end

  // R2: the chosen index is always a selected register
  a_r2_pick_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (mask != '0) |-> mask[idx]);
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [ADDR_W-1:0]        cmd_base,
  input  logic [NREG-1:0]          cmd_list,
  input  logic                     cmd_up,
  input  logic                     cmd_pre,
  input  logic                     cmd_wb,
  input  logic                     cmd_load,
  output logic                     beat_valid,
  input  logic                     beat_ready,
  output logic [ADDR_W-1:0]        beat_addr,
  output logic [$clog2(NREG)-1:0]  beat_reg,
  output logic                     beat_last,
  output logic                     beat_load,
  output logic                     seq_done,
  output logic                     done_wb,
  output logic [ADDR_W-1:0]        done_base,
  output logic                     list_err
);
  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = $clog2(NREG + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  seq_state_e        state_q;
  logic [NREG-1:0]   mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wbval_q;
  logic              load_q, wb_q, done_q, err_q;

  logic [CNT_W-1:0]  cmd_count;
  logic [ADDR_W-1:0] cmd_first, cmd_final;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_single;
  logic [NREG-1:0]   mask_rest;
  logic              cmd_fire, beat_fire;

  blkxfer_count #(.NREG(NREG), .CNT_W(CNT_W)) u_count (
    .mask  (cmd_list),
    .count (cmd_count)
  );

  blkxfer_span #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_span (
    .base       (cmd_base),
    .count      (cmd_count),
    .mode       (xfer_mode_e'({cmd_up, cmd_pre})),
    .first_addr (cmd_first),
    .final_base (cmd_final)
  );

  blkxfer_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask      (mask_q),
    .idx       (cur_idx),
    .single    (cur_single),
    .mask_rest (mask_rest)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign beat_fire = beat_valid && beat_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      wbval_q <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (cmd_fire) begin
        if (cmd_count == '0) begin
          err_q <= 1'b1;
        end else begin
          state_q <= ST_RUN;
          mask_q  <= cmd_list;
          addr_q  <= cmd_first;
          wbval_q <= cmd_final;
          load_q  <= cmd_load;
          wb_q    <= cmd_wb;
        end
      end else if (beat_fire) begin
        mask_q <= mask_rest;
        addr_q <= addr_q + STEP;
        if (cur_single) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign beat_valid = (state_q == ST_RUN);
  assign beat_addr  = addr_q;
  assign beat_reg   = cur_idx;
  assign beat_last  = cur_single;
  assign beat_load  = load_q;
  assign seq_done   = done_q;
  assign done_wb    = wb_q;
  assign done_base  = wbval_q;
  assign list_err   = err_q;

  // R5: a stalled beat holds still
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) &&
      $stable(beat_reg) && $stable(beat_last) && $stable(beat_load)));

  // R4: one word step per accepted beat
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !beat_last) |=> (beat_valid && beat_addr == $past(beat_addr) + STEP));

  // R4: word alignment
  a_r4_align: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_addr[1:0] == 2'b00));

  // R2: ascending register order
  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !beat_last) |=> (beat_reg > $past(beat_reg)));

  // R7: completion pulse follows the final beat, then drops
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && beat_last) |=> (seq_done && !beat_valid));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  // R8: an empty mask produces no beat
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    list_err |-> (!beat_valid && !seq_done));

  // R9: no command is taken while beats are pending
  a_r9_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !cmd_ready);
endmodule

// File: tb/sim_blkxfer_seq.sv
module sim_blkxfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_list = '0;
  logic        cmd_up = 1'b0, cmd_pre = 1'b0, cmd_wb = 1'b0, cmd_load = 1'b0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic [3:0]  beat_reg;
  logic        beat_last, beat_load;
  logic        seq_done, done_wb, list_err;
  logic [31:0] done_base;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  blkxfer_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base),
    .cmd_list(cmd_list), .cmd_up(cmd_up), .cmd_pre(cmd_pre), .cmd_wb(cmd_wb),
    .cmd_load(cmd_load),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_reg(beat_reg), .beat_last(beat_last), .beat_load(beat_load),
    .seq_done(seq_done), .done_wb(done_wb), .done_base(done_base), .list_err(list_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int n_set(input logic [15:0] m);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    return n;
  endfunction

  function automatic logic [3:0] kth_reg(input logic [15:0] m, input int k);
    int seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (seen == k) return 4'(i);
        seen++;
      end
    end
    return 4'd0;
  endfunction

  function automatic logic [31:0] first_of(input logic [31:0] b, input int n,
                                          input bit up, input bit pre);
    logic [31:0] span = 32'(n * 4);
    logic [31:0] a;
    if (up && !pre)       a = b;
    else if (up && pre)   a = b + 32'd4;
    else if (!up && !pre) a = b - span + 32'd4;
    else                  a = b - span;
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] final_of(input logic [31:0] b, input int n, input bit up);
    return up ? b + 32'(n * 4) : b - 32'(n * 4);
  endfunction

  task automatic run_cmd(input logic [31:0] b, input logic [15:0] m, input bit up,
                         input bit pre, input bit wb, input bit ld,
                         input int rdy_pct, input bit junk);
    int n = n_set(m);
    int k = 0;
    int guard = 0;
    logic [31:0] a0 = first_of(b, n, up, pre);
    bit rdy;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R9 ready when idle", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_base = b; cmd_list = m;
    cmd_up = up; cmd_pre = pre; cmd_wb = wb; cmd_load = ld;
    @(negedge clk);
    cmd_valid = junk;
    cmd_base = $urandom; cmd_list = 16'($urandom);
    cmd_up = 1'($urandom); cmd_pre = 1'($urandom); cmd_wb = 1'($urandom);
    cmd_load = 1'($urandom);
    if (n == 0) begin
      cmd_valid = 1'b0;
      check(list_err == 1'b1, "R8 empty mask error pulse", 32'(list_err), 32'd1);
      check(beat_valid == 1'b0, "R8 no beat for empty mask", 32'(beat_valid), 32'd0);
      @(negedge clk);
      check(list_err == 1'b0 && seq_done == 1'b0 && beat_valid == 1'b0,
            "R8 quiet after error", {29'd0, list_err, seq_done, beat_valid}, 32'd0);
      return;
    end
    while (k < n && guard < 400) begin
      guard++;
      check(beat_valid == 1'b1 && cmd_ready == 1'b0, "R9 busy beat pending",
            {30'd0, beat_valid, cmd_ready}, 32'd2);
      check(seq_done == 1'b0, "R7 no done mid-sequence", 32'(seq_done), 32'd0);
      rdy = (($urandom % 100) < rdy_pct);
      if (rdy) begin
        check(beat_reg == kth_reg(m, k), "R2 register index order", 32'(beat_reg),
              32'(kth_reg(m, k)));
        check(beat_addr == a0 + 32'(4 * k), "R3 R4 beat address", beat_addr,
              a0 + 32'(4 * k));
        check(beat_last == (k == n - 1), "R6 last flag", 32'(beat_last),
              32'(k == n - 1));
        check(beat_load == ld, "R6 load bit", 32'(beat_load), 32'(ld));
        if (k == n - 1) cmd_valid = 1'b0;
        k++;
      end
      beat_ready = rdy;
      @(negedge clk);
    end
    beat_ready = 1'b0;
    check(k == n, "R2 beat count", 32'(k), 32'(n));
    check(seq_done == 1'b1 && beat_valid == 1'b0, "R7 done pulse after last",
          {30'd0, seq_done, beat_valid}, 32'd2);
    check(done_base == final_of(b, n, up), "R7 written-back base", done_base,
          final_of(b, n, up));
    check(done_wb == wb, "R7 write-back flag", 32'(done_wb), 32'(wb));
    @(negedge clk);
    check(seq_done == 1'b0, "R7 done lasts one cycle", 32'(seq_done), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(beat_valid == 1'b0 && seq_done == 1'b0 && list_err == 1'b0 && cmd_ready == 1'b1,
          "R1 reset state", {28'd0, beat_valid, seq_done, list_err, cmd_ready}, 32'd1);
    // R3 descending push of five registers: stack pointer drops by 20
    run_cmd(32'h0000_1000, 16'h003B, 1'b0, 1'b1, 1'b1, 1'b0, 100, 1'b0);
    // R3 each mode on a full mask
    for (int md = 0; md < 4; md++)
      run_cmd(32'h0000_2000, 16'hFFFF, md[1], md[0], 1'b1, 1'b1, 60, 1'b1);
    // R2 single-bit masks at both ends
    run_cmd(32'h0000_3000, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b1, 100, 1'b0);
    run_cmd(32'h0000_3000, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b0, 40, 1'b1);
    // R10 wrap through zero
    run_cmd(32'h0000_0000, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0, 70, 1'b0);
    run_cmd(32'hFFFF_FFF8, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 70, 1'b1);
    // R4 unaligned base
    run_cmd(32'h0000_1003, 16'h0C30, 1'b1, 1'b1, 1'b1, 1'b1, 50, 1'b0);
    // R8 empty mask
    run_cmd(32'h0000_4000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 100, 1'b0);
    // random mix
    void'($urandom(32'd1234));
    for (int t = 0; t < 150; t++) begin
      logic [15:0] m = (($urandom % 10) == 0) ? 16'h0000 : 16'($urandom);
      run_cmd($urandom, m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              30 + int'($urandom % 71), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog actual=hung expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule